// File: doc/BRIEF.md
# Queued Bus Master Command Controller

This block is the master side of a synchronous parallel backplane bus. User logic hands it read and write commands through a valid/ready handshake on the user clock. The commands wait in a command queue that crosses into the bus clock domain. A bus engine takes them one at a time and runs each one as a bus transaction. It drives a one-cycle strobe with the address, access width, direction and data, and then waits until the addressed slave raises its ready line. For a read, the slave's data goes back to the user clock domain through a toggle handshake and shows up with a one-cycle valid pulse.

Each command picks its own width: full 32-bit access or 16-bit access, with the data right-justified. A per-command ECC-disable bit goes out on the bus unchanged. The block does no coding of its own. A watchdog counts the bus cycles during which a slave stalls a transaction. When the count wraps, the watchdog sets a sticky debug flag. Tristate buffers for the bus lines live outside the block.

Top module: `bus_cmd_master`

## Requirements
- R1: A command is taken only on a user clock edge where `cmd_valid` and `cmd_ready` are both high. The queue holds 2^FIFO_AW−1 commands (7 by default). `cmd_ready` goes low once that many are waiting. A command offered while `cmd_ready` is low never reaches the bus.
- R2: Commands run on the bus in the order they were taken. Each one shows `cmd_addr` on `bus_addr`, `cmd_wide` on `bus_wide` (1 = 32-bit, 0 = 16-bit) and `cmd_write` on `bus_write` (1 = write, 0 = read). These values hold steady until the transaction ends.
- R3: Each transaction has a strobe that lasts exactly one bus cycle. It ends on the first bus cycle after the strobe in which `bus_slave_rdy` is high. No new strobe appears before then.
- R4: A read delivers the `bus_din` value sampled in its completing cycle on `ret_data`, with a `ret_valid` pulse one user cycle long. A write produces no `ret_valid`.
- R5: In 16-bit mode the upper half of the data is forced to zero. For a write, `bus_dout[31:16]` is 0 during the strobe and `bus_dout[15:0]` equals `cmd_wdata[15:0]`. For a read, `ret_data[31:16]` is 0. In 32-bit mode all bits pass through.
- R6: `dbg_stall_overflow` rises once a single transaction has seen 2^WD_W (256 by default) bus cycles with `bus_slave_rdy` low after its strobe. It stays low for 255 such cycles. Once set, it stays set until bus reset.
- R7: After reset, `cmd_ready` is 1, `ret_valid` is 0, `bus_strobe` is 0, `dbg_stall_overflow` is 0 and the queue is empty.
- R8: The ECC control bit is active low: 0 enables ECC and 1 disables it. `cmd_ecc_off` appears unchanged on `bus_ecc_off` for its transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_user | input | 1 | User-side clock |
| rst_user_n | input | 1 | User-side asynchronous reset, active low |
| cmd_valid | input | 1 | Command offer |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_ecc_off | input | 1 | 0 enables ECC, 1 disables |
| cmd_wide | input | 1 | 1 = 32-bit, 0 = 16-bit |
| cmd_write | input | 1 | 1 = write, 0 = read |
| ret_valid | output | 1 | One-cycle read-return strobe |
| ret_data | output | DATA_W | Read-return data |
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Bus-side asynchronous reset, active low |
| bus_strobe | output | 1 | Transaction start strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wide | output | 1 | Bus access width |
| bus_write | output | 1 | Bus direction |
| bus_ecc_off | output | 1 | Bus ECC-disable bit |
| bus_dout | output | DATA_W | Write data toward the slave |
| bus_din | input | DATA_W | Read data from the slave |
| bus_slave_rdy | input | 1 | Slave ready; low stalls the transaction |
| dbg_stall_overflow | output | 1 | Sticky watchdog overflow flag |

## Verification
The assertions assume three things about the slave. It keeps `bus_slave_rdy` low in the strobe cycle. It raises the line for exactly one cycle to finish a transaction. It holds `bus_din` valid in that cycle. The bench's slave model drives these lines on the falling bus edge and follows the same pattern, with a stall length set from the address or forced by the test. The assertions also assume that the two resets are applied together or that the user side leaves reset first. The bench releases the user side first, so it can fill the queue while the bus side is still held in reset.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_WAIT  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOTAL = STAGES * W;
  logic [TOTAL-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[TOTAL-W-1:0], d};
  end

  assign q = chain[TOTAL-1 -: W];
endmodule

// File: rtl/bcm_async_fifo.sv
module bcm_async_fifo #(
  parameter int W    = 8,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = 1;

  function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW-1:0] from_gray(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_bin, wr_gray, wr_next, rd_gray_w;
  logic [AW-1:0] rd_bin, rd_gray, rd_next, wr_gray_r;
  logic          push, pop;

  bcm_sync #(.W(AW), .STAGES(SYNC)) u_rd2w (
    .clk(wclk), .rst_n(wrst_n), .d(rd_gray), .q(rd_gray_w));
  bcm_sync #(.W(AW), .STAGES(SYNC)) u_wr2r (
    .clk(rclk), .rst_n(rrst_n), .d(wr_gray), .q(wr_gray_r));

  // one slot kept free so that full and empty differ with AW-bit pointers
  assign wr_next = wr_bin + ONE;
  assign full    = (wr_next == from_gray(rd_gray_w));
  assign push    = wr_en && !full;

  always_ff @(posedge wclk) begin
    if (push) mem[wr_bin] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (push) begin
      wr_bin  <= wr_next;
      wr_gray <= to_gray(wr_next);
    end
  end

  assign rd_next = rd_bin + ONE;
  assign empty   = (rd_bin == from_gray(wr_gray_r));
  assign pop     = rd_en && !empty;
  assign rdata   = mem[rd_bin];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (pop) begin
      rd_bin  <= rd_next;
      rd_gray <= to_gray(rd_next);
    end
  end

  // R1: pointers crossing domains move one bit at a time
  assert_wr_gray_step_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  assert_rd_gray_step_R1: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/bcm_ret_xfer.sv
module bcm_ret_xfer #(
  parameter int DW   = 32,
  parameter int SYNC = 2
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          busy,
  input  logic          uclk,
  input  logic          urst_n,
  output logic          ret_valid,
  output logic [DW-1:0] ret_data
);
  logic [DW-1:0] hold;
  logic          req_tog, ack_b, req_u, req_seen;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      hold    <= '0;
      req_tog <= 1'b0;
    end else if (load) begin
      hold    <= din;
      req_tog <= ~req_tog;
    end
  end

  bcm_sync #(.W(1), .STAGES(SYNC)) u_req (
    .clk(uclk), .rst_n(urst_n), .d(req_tog), .q(req_u));
  bcm_sync #(.W(1), .STAGES(SYNC)) u_ack (
    .clk(bclk), .rst_n(brst_n), .d(req_seen), .q(ack_b));

  assign busy = req_tog ^ ack_b;

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) begin
      req_seen  <= 1'b0;
      ret_valid <= 1'b0;
      ret_data  <= '0;
    end else begin
      req_seen  <= req_u;
      ret_valid <= req_u ^ req_seen;
      if (req_u ^ req_seen) ret_data <= hold;
    end
  end

  // R4: each returned read is a single-cycle pulse
  assert_ret_pulse_R4: assert property (@(posedge uclk) disable iff (!urst_n)
    ret_valid |=> !ret_valid);
endmodule

// File: rtl/bcm_bus_engine.sv
module bcm_bus_engine
  import bcm_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int WD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [AW+DW+2:0] q_data,
  output logic             q_pop,
  input  logic             ret_busy,
  output logic             ret_load,
  output logic [DW-1:0]    ret_din,
  input  logic             slave_rdy,
  input  logic [DW-1:0]    bus_din,
  output logic             strobe,
  output logic [AW-1:0]    addr,
  output logic             wide,
  output logic             write,
  output logic             ecc_off,
  output logic [DW-1:0]    dout,
  output logic             wd_flag
);
  localparam int HALF = DW / 2;

  function automatic logic [DW-1:0] fit_data(input logic [DW-1:0] d, input logic w);
    logic [DW-1:0] m;
    m = '0;
    m[HALF-1:0] = '1;
    return w ? d : (d & m);
  endfunction

  eng_state_t      state;
  logic [WD_W-1:0] wd_cnt;
  logic            in_wait, done, wd_wrap;
  logic            c_ecc, c_wide, c_write;
  logic [AW-1:0]   c_addr;
  logic [DW-1:0]   c_wdata;

  assign {c_ecc, c_wide, c_write, c_addr, c_wdata} = q_data;

  assign q_pop    = (state == ENG_IDLE) && !q_empty && !ret_busy;
  assign strobe   = (state == ENG_ISSUE);
  assign in_wait  = (state == ENG_WAIT);
  assign done     = in_wait && slave_rdy;
  assign wd_wrap  = in_wait && !slave_rdy && (wd_cnt == '1);
  assign ret_load = done && !write;
  assign ret_din  = fit_data(bus_din, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      addr    <= '0;
      wide    <= 1'b0;
      write   <= 1'b0;
      ecc_off <= 1'b0;
      dout    <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (q_pop) begin
          addr    <= c_addr;
          wide    <= c_wide;
          write   <= c_write;
          ecc_off <= c_ecc;
          dout    <= c_write ? fit_data(c_wdata, c_wide) : '0;
          state   <= ENG_ISSUE;
        end
        ENG_ISSUE: state <= ENG_WAIT;
        ENG_WAIT:  if (slave_rdy) state <= ENG_IDLE;
        default:   state <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      wd_flag <= 1'b0;
    end else begin
      if (strobe) wd_cnt <= '0;
      else if (in_wait && !slave_rdy) wd_cnt <= wd_cnt + 1'b1;
      if (wd_wrap) wd_flag <= 1'b1;
    end
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  assert_no_strobe_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !strobe);
  assert_hold_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> ($stable(addr) && $stable(write) && $stable(wide)));
  assert_narrow_dout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wide) |-> (dout[DW-1:HALF] == '0));
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_flag |=> wd_flag);
endmodule

// File: rtl/bus_cmd_master.sv
module bus_cmd_master #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int FIFO_AW     = 3,
  parameter int WD_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_user,
  input  logic              rst_user_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ecc_off,
  input  logic              cmd_wide,
  input  logic              cmd_write,
  output logic              ret_valid,
  output logic [DATA_W-1:0] ret_data,
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  output logic              bus_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wide,
  output logic              bus_write,
  output logic              bus_ecc_off,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_slave_rdy,
  output logic              dbg_stall_overflow
);
  localparam int CMD_W = ADDR_W + DATA_W + 3;

  logic [CMD_W-1:0]  q_wdata, q_rdata;
  logic              q_full, q_empty, q_pop;
  logic              ret_busy, ret_load;
  logic [DATA_W-1:0] ret_din;

  assign q_wdata   = {cmd_ecc_off, cmd_wide, cmd_write, cmd_addr, cmd_wdata};
  assign cmd_ready = !q_full;

  bcm_async_fifo #(.W(CMD_W), .AW(FIFO_AW), .SYNC(SYNC_STAGES)) u_queue (
    .wclk(clk_user), .wrst_n(rst_user_n), .wr_en(cmd_valid), .wdata(q_wdata),
    .full(q_full),
    .rclk(clk_bus), .rrst_n(rst_bus_n), .rd_en(q_pop), .rdata(q_rdata),
    .empty(q_empty));

  bcm_bus_engine #(.AW(ADDR_W), .DW(DATA_W), .WD_W(WD_W)) u_engine (
    .clk(clk_bus), .rst_n(rst_bus_n),
    .q_empty(q_empty), .q_data(q_rdata), .q_pop(q_pop),
    .ret_busy(ret_busy), .ret_load(ret_load), .ret_din(ret_din),
    .slave_rdy(bus_slave_rdy), .bus_din(bus_din),
    .strobe(bus_strobe), .addr(bus_addr), .wide(bus_wide), .write(bus_write),
    .ecc_off(bus_ecc_off), .dout(bus_dout), .wd_flag(dbg_stall_overflow));

  bcm_ret_xfer #(.DW(DATA_W), .SYNC(SYNC_STAGES)) u_return (
    .bclk(clk_bus), .brst_n(rst_bus_n), .load(ret_load), .din(ret_din),
    .busy(ret_busy),
    .uclk(clk_user), .urst_n(rst_user_n), .ret_valid(ret_valid),
    .ret_data(ret_data));

  // R7: out of reset the queue is empty, so the user side may offer a command
  assert_ready_after_reset_R7: assert property (@(posedge clk_user) disable iff (!rst_user_n)
    $rose(rst_user_n) |-> cmd_ready);
endmodule

// File: tb/bus_cmd_master_bench.sv
module bus_cmd_master_bench;
  logic        clk_user = 0, clk_bus = 0;
  logic        rst_user_n = 0, rst_bus_n = 0;
  logic        cmd_valid = 0, cmd_ready;
  logic [15:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ecc_off = 0, cmd_wide = 0, cmd_write = 0;
  logic        ret_valid;
  logic [31:0] ret_data;
  logic        bus_strobe, bus_wide, bus_write, bus_ecc_off;
  logic [15:0] bus_addr;
  logic [31:0] bus_dout;
  logic [31:0] bus_din = '0;
  logic        bus_slave_rdy = 0;
  logic        dbg_stall_overflow;

  int checks = 0, errors = 0;
  int stall_force = -1;

  typedef struct packed {
    logic [15:0] a;
    logic        wide, write, ecc;
    logic [31:0] d;
  } bus_exp_t;
  bus_exp_t    exp_bus[$];
  logic [31:0] exp_ret[$];

  always #5 clk_user = ~clk_user;   // 100 MHz
  always #7 clk_bus  = ~clk_bus;

  bus_cmd_master u_bus_cmd_master (.*);

  function automatic logic [31:0] fit(input logic [31:0] d, input logic w);
    return w ? d : {16'h0000, d[15:0]};
  endfunction

  function automatic logic [31:0] slave_word(input logic [15:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [31:0] d,
                      input logic ecc, input logic w, input logic wr);
    bus_exp_t e;
    @(negedge clk_user);
    cmd_addr = a; cmd_wdata = d; cmd_ecc_off = ecc; cmd_wide = w; cmd_write = wr;
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk_user);
    @(posedge clk_user);
    e.a = a; e.wide = w; e.write = wr; e.ecc = ecc; e.d = fit(d, w);
    exp_bus.push_back(e);
    if (!wr) exp_ret.push_back(fit(slave_word(a), w));
    #1 cmd_valid = 0;
  endtask

  task automatic drain();
    while (exp_bus.size() != 0 || exp_ret.size() != 0) @(negedge clk_user);
    repeat (20) @(negedge clk_user);
  endtask

  // slave model and bus monitor
  int          sl_state = 0, sl_cnt = 0;
  logic [15:0] sl_addr;
  always @(negedge clk_bus) begin
    if (!rst_bus_n) begin
      sl_state = 0; bus_slave_rdy = 0;
    end else begin
      if (bus_strobe && sl_state != 0)
        check(0, "R3 strobe during open transaction", 32'(bus_strobe), 0);
      case (sl_state)
        0: if (bus_strobe) begin
          if (exp_bus.size() == 0) begin
            check(0, "R1 unexpected bus command", 32'(bus_addr), 0);
          end else begin
            bus_exp_t e;
            e = exp_bus.pop_front();
            check(bus_addr == e.a, "R2 address order", 32'(bus_addr), 32'(e.a));
            check(bus_wide == e.wide && bus_write == e.write, "R2 mode/direction",
                  {30'd0, bus_wide, bus_write}, {30'd0, e.wide, e.write});
            check(bus_ecc_off == e.ecc, "R8 ecc bit", 32'(bus_ecc_off), 32'(e.ecc));
            if (e.write)
              check(bus_dout == e.d, "R5 write data fit", bus_dout, e.d);
          end
          sl_addr = bus_addr;
          sl_cnt = (stall_force >= 0) ? stall_force : int'(bus_addr[1:0]) * 3;
          sl_state = 1;
        end
        1: if (sl_cnt == 0) begin
          bus_slave_rdy = 1; bus_din = slave_word(sl_addr); sl_state = 2;
        end else sl_cnt--;
        default: begin
          bus_slave_rdy = 0; bus_din = 32'hDEAD_BEEF; sl_state = 0;
        end
      endcase
    end
  end

  // return monitor
  always @(negedge clk_user) begin
    if (rst_user_n && ret_valid) begin
      if (exp_ret.size() == 0) check(0, "R4 return without read", ret_data, 0);
      else begin
        logic [31:0] x;
        x = exp_ret.pop_front();
        check(ret_data == x, "R4 R5 read return data", ret_data, x);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_user);
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_user);
    rst_user_n = 1;
    repeat (3) @(negedge clk_user);
    // R7 reset state
    check(cmd_ready == 1, "R7 ready after reset", 32'(cmd_ready), 1);
    check(ret_valid == 0, "R7 no return after reset", 32'(ret_valid), 0);
    check(bus_strobe == 0, "R7 strobe idle after reset", 32'(bus_strobe), 0);
    check(dbg_stall_overflow == 0, "R7 flag clear", 32'(dbg_stall_overflow), 0);

    // R1: fill the queue while the bus side is held in reset
    for (int i = 0; i < 7; i++)
      send(16'h1000 + 16'(i), 32'hA5A5_0000 + 32'(i), 1'(i % 2), 1'(i % 3 == 0),
           1'(i % 2));
    @(negedge clk_user);
    check(cmd_ready == 0, "R1 ready low at capacity", 32'(cmd_ready), 0);
    cmd_addr = 16'hBAD0; cmd_write = 1; cmd_valid = 1;   // must not be taken
    repeat (3) @(negedge clk_user);
    cmd_valid = 0;
    rst_bus_n = 1;
    drain();
    check(cmd_ready == 1, "R1 ready back after drain", 32'(cmd_ready), 1);

    // R2 R4 R5 R8: mixed reads and writes, both widths, various stalls
    for (int i = 0; i < 12; i++)
      send(16'h2F00 + 16'(i * 5), 32'hC3C3_9696 ^ 32'(i << 4), 1'(i % 3 == 1),
           1'(i % 2), 1'(i % 4 == 0));
    drain();
    // back-to-back narrow reads of upper-heavy words
    for (int i = 0; i < 4; i++) send(16'hFFF0 + 16'(i), '0, 0, 0, 0);
    drain();

    // R6 watchdog: 255 stalled cycles do not trip, 256 do, then sticky
    stall_force = 255;
    send(16'h3000, '0, 0, 1, 0);
    drain();
    check(dbg_stall_overflow == 0, "R6 no flag at 255", 32'(dbg_stall_overflow), 0);
    stall_force = 256;
    send(16'h3004, '0, 0, 1, 0);
    drain();
    check(dbg_stall_overflow == 1, "R6 flag at 256", 32'(dbg_stall_overflow), 1);
    stall_force = 0;
    send(16'h3008, 32'h1234_5678, 0, 1, 1);
    drain();
    check(dbg_stall_overflow == 1, "R6 flag sticky", 32'(dbg_stall_overflow), 1);
    check(exp_bus.size() == 0, "R2 all commands ran", 32'(exp_bus.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule